// File: doc/BRIEF.md
# Accumulator CPU With Nibble Instructions

This block is a very small accumulator processor. It is tied to a private 16-byte memory that holds both code and data. By convention the lower eight bytes hold the program and the upper eight hold operands.

Each instruction is one byte. The high nibble selects the operation and the low nibble names the memory byte it works on. A sequencer steps through the machine's registers one transfer at a time:

- program counter to address register;
- memory to data register;
- data register to instruction register;
- instruction address field to address register;
- memory to data register;
- data register to the accumulator or the adder.

A halt opcode parks the machine and raises a status pin.

A program is placed in memory through a valid/ready load stream, and only while reset is held. The stream signals ready for exactly as long as `rst_n` is low. A byte is taken on every rising clock edge where valid and ready are both high. While the core runs, ready stays low and any valid beat is dropped, so the producer must hold its data until the core is back in reset. A combinational debug read port and the program counter, accumulator, carry and halt pins let the memory and the machine state be observed.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `pc`, `acc` and `carry` read 0 and `halt` reads 0.
- R2: An instruction byte carries the opcode in bits 7:4 and the operand address in bits 3:0. The opcode values are 0001 load, 0010 add, 0011 store and 1111 halt. Every other opcode does nothing but advance to the next byte.
- R3: Execution begins at address 0 after reset is released. `pc` rises by exactly one (modulo 16) once per instruction fetch and holds at every other time.
- R4: Load places memory[addr] in `acc` and leaves `carry` unchanged.
- R5: Add sets `acc` to (acc + memory[addr]) mod 256 and sets `carry` to the carry-out of that sum. No other instruction alters `carry`.
- R6: Store writes `acc` into memory[addr] and leaves `acc` and `carry` unchanged.
- R7: Counted in rising edges from reset release until `halt` reads 1, a no-op takes 4 cycles, halt 4, store 5, and load or add 6.
- R8: After a halt, `halt` stays 1 until reset. `pc` holds the halt byte's address plus one, and `acc`, `carry` and memory stay unchanged.
- R9: `ld_ready` equals the inverse of `rst_n`. A byte is written to memory[`ld_addr`] at each rising edge with `ld_valid` and `ld_ready` high. A valid beat while running has no effect on memory, even when it targets the address a store is writing in that cycle.
- R10: The program load 8, add 9, store 10 (bytes 18h, 29h, 3Ah, then F0h), run with memory[8]=2 and memory[9]=3, leaves 5 in memory[10].
- R11: `dbg_data` shows memory[`dbg_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset; the load stream is open while low |
| ld_valid | input | 1 | Load stream beat valid |
| ld_ready | output | 1 | Load stream ready; high only during reset |
| ld_addr | input | 4 | Memory address of the load beat |
| ld_data | input | 8 | Byte of the load beat |
| dbg_addr | input | 4 | Debug read address |
| dbg_data | output | 8 | Memory byte at `dbg_addr` |
| pc | output | 4 | Program counter |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry-out of the last add |
| halt | output | 1 | High once a halt opcode has executed |

## Verification
Two writers share the memory: the load stream and the core's store step. The bench provokes a collision by holding `ld_valid` high with the store's own target address and a marker byte for the whole run. The run is judged by reading every memory byte after halt and requiring the stored accumulator value, never the marker. A second overlap is the carry flag: a load that follows an add must leave it untouched. Random programs that mix adds and loads check this against a bench model.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_STORE = 4'h3;
  localparam logic [OPW-1:0] OP_HALT  = 4'hF;

  // one state per register transfer
  typedef enum logic [2:0] {
    S_F1,   // pc -> mar
    S_F2,   // mem -> mdr
    S_F3,   // mdr -> ir, pc + 1
    S_E1,   // ir address -> mar, or decide nop / halt
    S_E2,   // mem -> mdr, or store acc
    S_E3,   // mdr -> acc, or acc + mdr -> acc
    S_HLT
  } seq_state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[DW-1:0];
    cout = wide[DW];
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we)        cells[ld_addr]   <= ld_data;
    else if (core_we) cells[core_addr] <= core_wdata;
  end

  assign core_rdata = cells[core_addr];
  assign dbg_data   = cells[dbg_addr];

  // R9: the load stream and the core never write in the same cycle
  a_r9_single_writer: assert property (@(posedge clk) ld_we |-> !core_we)
    else $error("load and store write together");
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          carry,
  output logic          halt
);
  localparam int OW = DW - AW;

  seq_state_e    st_q;
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mdr_q, ir_q, acc_q;
  logic          carry_q;
  logic [OW-1:0] op;
  logic [AW-1:0] opnd;
  logic [DW-1:0] sum;
  logic          cout;

  assign op   = ir_q[DW-1:AW];
  assign opnd = ir_q[AW-1:0];

  acc_alu #(.DW(DW)) u_alu (
    .a    (acc_q),
    .b    (mdr_q),
    .sum  (sum),
    .cout (cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_F1;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      case (st_q)
        S_F1: begin
          mar_q <= pc_q;
          st_q  <= S_F2;
        end
        S_F2: begin
          mdr_q <= mem_rdata;
          st_q  <= S_F3;
        end
        S_F3: begin
          ir_q <= mdr_q;
          pc_q <= pc_q + AW'(1);
          st_q <= S_E1;
        end
        S_E1: begin
          if (op == OP_LOAD || op == OP_ADD || op == OP_STORE) begin
            mar_q <= opnd;
            st_q  <= S_E2;
          end else if (op == OP_HALT) begin
            st_q <= S_HLT;
          end else begin
            st_q <= S_F1;
          end
        end
        S_E2: begin
          if (op == OP_STORE) begin
            st_q <= S_F1;
          end else begin
            mdr_q <= mem_rdata;
            st_q  <= S_E3;
          end
        end
        S_E3: begin
          if (op == OP_ADD) begin
            acc_q   <= sum;
            carry_q <= cout;
          end else begin
            acc_q <= mdr_q;
          end
          st_q <= S_F1;
        end
        default: st_q <= S_HLT;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_we    = (st_q == S_E2) && (op == OP_STORE);
  assign mem_wdata = acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign carry     = carry_q;
  assign halt      = (st_q == S_HLT);

  // R3: the counter steps by one after a fetch and holds otherwise
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_F3) |=> (pc_q == $past(pc_q) + AW'(1)))
    else $error("pc did not step");
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_F3) |=> $stable(pc_q))
    else $error("pc moved outside fetch");
  // R4: a load copies the data register into the accumulator
  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_E3 && op == OP_LOAD) |=> (acc_q == $past(mdr_q)))
    else $error("load result wrong");
  // R5: carry changes only on the add step
  a_r5_carry_add_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q == S_E3 && op == OP_ADD) |=> $stable(carry_q))
    else $error("carry changed outside add");
  // R8: a halted core stays frozen
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(pc_q) && $stable(acc_q) && !mem_we))
    else $error("halted core moved");
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          carry,
  output logic          halt
);
  logic          ld_we;
  logic [AW-1:0] m_addr;
  logic          m_we;
  logic [DW-1:0] m_wdata, m_rdata;

  assign ld_ready = !rst_n;
  assign ld_we    = ld_valid && ld_ready;

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk        (clk),
    .ld_we      (ld_we),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .core_we    (m_we),
    .core_addr  (m_addr),
    .core_wdata (m_wdata),
    .core_rdata (m_rdata),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data)
  );

  acc_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (m_rdata),
    .mem_addr  (m_addr),
    .mem_we    (m_we),
    .mem_wdata (m_wdata),
    .pc        (pc),
    .acc       (acc),
    .carry     (carry),
    .halt      (halt)
  );

  // R6: a store writes the accumulator value
  a_r6_store_value: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |=> (dbg_addr != $past(m_addr)) || (dbg_data == $past(acc)))
    else $error("stored byte differs from accumulator");
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic [3:0] pc;
  logic [7:0] acc;
  logic       carry, halt;

  int checks = 0;
  int failures = 0;

  logic [7:0] img [16];
  logic [7:0] exp_mem [16];
  logic [7:0] exp_acc;
  logic       exp_carry;
  logic [3:0] exp_pc;
  int         exp_cyc;

  always #2 clk = ~clk;

  acc_core i_acc_core (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .pc(pc), .acc(acc), .carry(carry), .halt(halt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model();
    logic [7:0] a = 8'h00;
    logic       c = 1'b0;
    logic [3:0] p = 4'h0;
    logic [8:0] w;
    int         cyc = 0;
    for (int i = 0; i < 16; i++) exp_mem[i] = img[i];
    for (int s = 0; s < 64; s++) begin
      logic [7:0] b = exp_mem[p];
      p = p + 4'd1;
      if (b[7:4] == 4'h1) begin
        a = exp_mem[b[3:0]]; cyc += 6;
      end else if (b[7:4] == 4'h2) begin
        w = {1'b0, a} + {1'b0, exp_mem[b[3:0]]};
        a = w[7:0]; c = w[8]; cyc += 6;
      end else if (b[7:4] == 4'h3) begin
        exp_mem[b[3:0]] = a; cyc += 5;
      end else if (b[7:4] == 4'hF) begin
        cyc += 4;
        break;
      end else begin
        cyc += 4;
      end
    end
    exp_acc = a; exp_carry = c; exp_pc = p; exp_cyc = cyc;
  endtask

  task automatic load_image();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc in reset", int'(pc), 0);
    chk("R1", "acc in reset", int'(acc), 0);
    chk("R1", "carry/halt in reset", int'({carry, halt}), 0);
    chk("R9", "ready in reset", int'(ld_ready), 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 4'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_valid = 1'b0;
    dbg_addr = 4'd0;
    #1;
    chk("R11", "debug read after load", int'(dbg_data), int'(img[0]));
  endtask

  task automatic run(input bit noise, input logic [3:0] naddr, input string tag);
    int cyc = 0;
    model();
    @(negedge clk);
    rst_n = 1'b1;
    if (noise) begin
      ld_valid = 1'b1; ld_addr = naddr; ld_data = 8'hA5;
    end
    #1;
    chk("R9", "ready while running", int'(ld_ready), 0);
    while (!halt && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk("R8", {tag, " halt"}, int'(halt), 1);
    chk("R7", {tag, " cycles"}, cyc, exp_cyc);
    chk("R3", {tag, " pc"}, int'(pc), int'(exp_pc));
    chk("R4", {tag, " acc"}, int'(acc), int'(exp_acc));
    chk("R5", {tag, " carry"}, int'(carry), int'(exp_carry));
    for (int i = 0; i < 16; i++) begin
      dbg_addr = 4'(i);
      #1;
      chk("R6", {tag, " memory"}, int'(dbg_data), int'(exp_mem[i]));
    end
    repeat (5) @(negedge clk);
    ld_valid = 1'b0;
    chk("R8", {tag, " held pc/acc/halt"}, int'({pc, acc, halt}), int'({exp_pc, exp_acc, 1'b1}));
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (2) @(negedge clk);

    // R10: reference addition program
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h18; img[1] = 8'h29; img[2] = 8'h3A; img[3] = 8'hF0;
    img[8] = 8'd2;  img[9] = 8'd3;
    load_image();
    run(1'b0, 4'd0, "R10");
    dbg_addr = 4'd10;
    #1;
    chk("R10", "sum stored", int'(dbg_data), 5);

    // R5: overflow sets carry, a following load keeps it
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h18; img[1] = 8'h29; img[2] = 8'h1B; img[3] = 8'hF0;
    img[8] = 8'hF0; img[9] = 8'h20; img[11] = 8'h07;
    load_image();
    run(1'b0, 4'd0, "R5 carry");
    chk("R5", "carry kept by load", int'(carry), 1);

    // R2: unused opcodes are no-ops
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h0C; img[1] = 8'h4D; img[2] = 8'hE8; img[3] = 8'h19; img[4] = 8'hF3;
    img[9] = 8'h77;
    load_image();
    run(1'b0, 4'd0, "R2 nop");
    chk("R2", "nop cycles", exp_cyc, 4 * 4 + 6);

    // R9: load beat on the store target during the run
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    img[0] = 8'h1E; img[1] = 8'h3C; img[2] = 8'hFF; img[14] = 8'h3C;
    load_image();
    run(1'b1, 4'd12, "R9 collide");
    dbg_addr = 4'd12;
    #1;
    chk("R9", "store wins over dropped beat", int'(dbg_data), 8'h3C);

    // random programs
    for (int t = 0; t < 60; t++) begin
      int len = 1 + int'($urandom % 7);
      for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
      for (int i = 0; i < len; i++) begin
        int k = int'($urandom % 4);
        logic [3:0] ad = 4'(8 + ($urandom % 8));
        logic [3:0] oc;
        if (k == 0) oc = 4'h1;
        else if (k == 1) oc = 4'h2;
        else if (k == 2) oc = 4'h3;
        else begin
          int n = int'($urandom % 12);
          oc = (n == 0) ? 4'h0 : 4'(n + 3);
        end
        img[i] = {oc, ad};
      end
      img[len] = {4'hF, 4'($urandom)};
      load_image();
      run(t[0], 4'(8 + ($urandom % 8)), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule